// File: doc/BRIEF.md
# Standby Power Mode Controller

This block moves a small microcontroller between normal running and three sleep depths, and drives the clock enables for each depth. The enables go to the oscillator, the PLL, the CPU clock tree, the peripheral clock tree and the external clock-output pin. Light sleep gates only the CPU clock. It is entered by a one-cycle pulse that the core raises when it executes its halt instruction. Medium sleep gates every internal clock but leaves the oscillator and PLL running, so it wakes at once. Deep sleep switches off the oscillator and the PLL. It is left only through a counted oscillator settling wait, and a configuration bit can add a PLL lock wait after that.

Medium and deep sleep are requested through a memory-mapped control register. A write to it is accepted only if the bus access just before it wrote the unlock key to the key address. Any other read or write in between cancels the unlock. An enabled interrupt or a non-maskable interrupt ends any sleep depth. Reset starts the block inside the longest oscillator settling wait.

Top module: `standby_ctrl`

## Requirements
- R1: After reset, `mode` reads 3, `osc_en` is 1, and `pll_en`, `cpu_clk_en`, `per_clk_en` and `clkout_en` are 0. This holds for 2^(OSC_EXP_BASE+6) cycles, and then all enables are 1 and `mode` reads 0.
- R2: In normal running, a `halt_req` pulse sets `mode` to 1 on the next cycle, with `cpu_clk_en` 0 and `osc_en`, `pll_en` and `per_clk_en` 1. `halt_req` is ignored in every other state.
- R3: An accepted control write with bits [1:0] = 01 enters medium sleep: `mode` is 2, `cpu_clk_en` and `per_clk_en` are 0, and `osc_en` and `pll_en` are 1.
- R4: From light or medium sleep, a wake event returns to `mode` 0 with all clocks enabled on the next cycle, with no settling wait.
- R5: An accepted control write with bits [1:0] = 10 enters deep sleep: `mode` is 3 and every enable output is 0. Values 00 and 11 in bits [1:0] request nothing.
- R6: A wake event in deep sleep starts a settling wait. During it `osc_en` is 1, the other enables are 0 and `mode` is 3. The wait lasts 2^(OSC_EXP_BASE+2*S) cycles, where S is control bits [4:3].
- R7: If control bit 5 is set, the settling wait is followed by a PLL wait with `pll_en` 1 and the clocks still off. That wait ends on the cycle after `pll_lock` is seen high, or after 2^PLL_EXP cycles.
- R8: Control bit 2 inhibits the clock-output pin: `clkout_en` equals `per_clk_en` when the bit is 0 and is 0 when it is 1, whatever the sleep depth.
- R9: The key is 0xA5 at address 0 and the control register is at address 1. A control write takes effect only when the bus access just before it was a key write. A control write with no key before it, or with any other access in between, changes neither the register nor the mode.
- R10: `irq_wake` and `nmi` each release a sleep depth on their own.
- R11: A read of address 1 returns {2'b00, bit5, bits[4:3], bit2, 2'b00}. The request field reads as zero. Reset values are S = 3 and bits 5 and 2 clear, so the register reads 0x18 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req | input | 1 | One-cycle pulse from the core's halt instruction |
| irq_wake | input | 1 | An enabled, unmasked interrupt is pending |
| nmi | input | 1 | Non-maskable interrupt |
| pll_lock | input | 1 | PLL reports lock |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data |
| osc_en | output | 1 | Oscillator enable |
| pll_en | output | 1 | PLL enable |
| cpu_clk_en | output | 1 | CPU clock gate enable |
| per_clk_en | output | 1 | Peripheral clock gate enable |
| clkout_en | output | 1 | External clock-output pin enable |
| mode | output | 2 | 0 normal, 1 light, 2 medium, 3 deep or waiting |

## Verification
The hardest states to reach are the PLL wait and its two exits. Getting there takes the full chain: an unlock, a deep-sleep write with the PLL bit set, a wake, and the whole settling wait. The bench runs with small exponent parameters, so that chain fits in a few hundred cycles. It then reaches the PLL wait twice: once it holds `pll_lock` low for a while and then raises it, and once it never raises it so the timeout ends the wait. The unlock rule is probed with a read and with a write to a third address between the key and the control write.

// File: rtl/standby_ctrl.sv
module standby_ctrl #(
  parameter int DW = 8,
  parameter int AW = 2,
  parameter logic [DW-1:0] UNLOCK_KEY = 'hA5,
  parameter int OSC_EXP_BASE = 12,
  parameter int PLL_EXP = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt_req,
  input  logic          irq_wake,
  input  logic          nmi,
  input  logic          pll_lock,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          osc_en,
  output logic          pll_en,
  output logic          cpu_clk_en,
  output logic          per_clk_en,
  output logic          clkout_en,
  output logic [1:0]    mode
);
  localparam int OSC_EXP_MAX = OSC_EXP_BASE + 6;
  localparam int CW = ((OSC_EXP_MAX > PLL_EXP) ? OSC_EXP_MAX : PLL_EXP) + 1;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};
  localparam logic [CW-1:0] PLL_LOAD = (ONE << PLL_EXP) - ONE;
  localparam logic [CW-1:0] RST_LOAD = (ONE << OSC_EXP_MAX) - ONE;
  localparam logic [AW-1:0] ADDR_KEY = '0;
  localparam logic [AW-1:0] ADDR_CTRL = AW'(1);

  typedef enum logic [2:0] {S_RUN, S_HALT, S_IDLE, S_STOP, S_OSC, S_PLL} st_t;

  st_t           st, st_nxt;
  logic [CW-1:0] cnt, cnt_nxt, osc_load;
  logic          armed, inhibit, pll_wait;
  logic [1:0]    sel;

  wire key_wr  = bus_wr && bus_addr == ADDR_KEY && bus_wdata == UNLOCK_KEY;
  wire ctrl_ok = bus_wr && bus_addr == ADDR_CTRL && armed;
  wire req_idle = ctrl_ok && bus_wdata[1:0] == 2'b01;
  wire req_stop = ctrl_ok && bus_wdata[1:0] == 2'b10;
  wire wake = irq_wake | nmi;

  assign osc_load = (ONE << (OSC_EXP_BASE + 2 * int'(sel))) - ONE;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed    <= 1'b0;
      inhibit  <= 1'b0;
      pll_wait <= 1'b0;
      sel      <= 2'b11;
    end else begin
      if (key_wr) armed <= 1'b1;
      else if (bus_wr || bus_rd) armed <= 1'b0;
      if (ctrl_ok) begin
        inhibit  <= bus_wdata[2];
        sel      <= bus_wdata[4:3];
        pll_wait <= bus_wdata[5];
      end
    end

  always_comb begin
    st_nxt  = st;
    cnt_nxt = cnt;
    case (st)
      S_RUN:
        if (req_stop) st_nxt = S_STOP;
        else if (req_idle) st_nxt = S_IDLE;
        else if (halt_req) st_nxt = S_HALT;
      S_HALT, S_IDLE:
        if (wake) st_nxt = S_RUN;
      S_STOP:
        if (wake) begin
          st_nxt  = S_OSC;
          cnt_nxt = osc_load;
        end
      S_OSC:
        if (cnt == '0) begin
          if (pll_wait) begin
            st_nxt  = S_PLL;
            cnt_nxt = PLL_LOAD;
          end else st_nxt = S_RUN;
        end else cnt_nxt = cnt - ONE;
      S_PLL:
        if (pll_lock || cnt == '0) st_nxt = S_RUN;
        else cnt_nxt = cnt - ONE;
      default: st_nxt = S_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st  <= S_OSC;
      cnt <= RST_LOAD;
    end else begin
      st  <= st_nxt;
      cnt <= cnt_nxt;
    end

  assign osc_en     = st != S_STOP;
  assign pll_en     = st != S_STOP && st != S_OSC;
  assign cpu_clk_en = st == S_RUN;
  assign per_clk_en = st == S_RUN || st == S_HALT;
  assign clkout_en  = per_clk_en && !inhibit;
  assign mode       = (st == S_RUN) ? 2'd0 : (st == S_HALT) ? 2'd1 :
                      (st == S_IDLE) ? 2'd2 : 2'd3;
  assign bus_rdata  = (bus_addr == ADDR_CTRL) ? DW'({pll_wait, sel, inhibit, 2'b00}) : '0;
endmodule

// File: rtl/standby_ctrl_chk.sv
module standby_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_req,
  input logic       irq_wake,
  input logic       nmi,
  input logic       pll_lock,
  input logic       bus_wr,
  input logic       osc_en,
  input logic       pll_en,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       clkout_en,
  input logic [1:0] mode
);
  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    halt_req && cpu_clk_en && !bus_wr |=> mode == 2'd1 && per_clk_en && !cpu_clk_en); // R2
  AST_IDLE_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd2 |-> !per_clk_en && !cpu_clk_en && osc_en && pll_en); // R3
  AST_FAST_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 || mode == 2'd2) && (irq_wake || nmi) |=> cpu_clk_en && mode == 2'd0); // R4
  AST_STOP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> mode == 2'd3 && !pll_en && !cpu_clk_en && !per_clk_en); // R5
  AST_OSC_WAIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_en) |-> !pll_en && !cpu_clk_en && !per_clk_en); // R6
  AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 2'd3 && osc_en && pll_en && pll_lock |=> cpu_clk_en); // R7
  AST_CLKOUT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    clkout_en |-> per_clk_en); // R8
endmodule

bind standby_ctrl standby_ctrl_chk u_chk (.*);

// File: tb/test_standby_ctrl.sv
module test_standby_ctrl;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       halt_req = 0, irq_wake = 0, nmi = 0, pll_lock = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       osc_en, pll_en, cpu_clk_en, per_clk_en, clkout_en;
  logic [1:0] mode;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  standby_ctrl #(.OSC_EXP_BASE(4), .PLL_EXP(5)) i_standby_ctrl (.*);

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    bus_rd = 1; bus_addr = a;
    #1 d = bus_rdata;
    step();
    bus_rd = 0;
  endtask

  task automatic unlocked_write(input logic [7:0] d);
    bus_write(2'd0, 8'hA5);
    bus_write(2'd1, d);
  endtask

  task automatic pulse_wake(input bit use_nmi);
    if (use_nmi) nmi = 1; else irq_wake = 1;
    step();
    nmi = 0; irq_wake = 0;
  endtask

  task automatic t_reset();
    int n = 0;
    logic [7:0] d;
    rst_n = 0; step(); step(); rst_n = 1;
    chk("R1 mode", mode, 3);
    chk("R1 enables", {osc_en, pll_en, cpu_clk_en, per_clk_en, clkout_en}, 5'b10000);
    while (!cpu_clk_en && n < 5000) begin step(); n++; end
    chk("R1 wait length", n, 1024);
    chk("R1 all on", {osc_en, pll_en, cpu_clk_en, per_clk_en, clkout_en, mode}, 7'b1111100);
    bus_read(2'd1, d);
    chk("R11 reset readback", d, 8'h18);
  endtask

  task automatic t_halt();
    halt_req = 1; step(); halt_req = 0;
    chk("R2 mode", mode, 1);
    chk("R2 enables", {osc_en, pll_en, cpu_clk_en, per_clk_en}, 4'b1101);
    halt_req = 1; step(); halt_req = 0;
    chk("R2 ignored in halt", mode, 1);
    pulse_wake(0);
    chk("R4 halt release", {cpu_clk_en, mode}, 3'b100);
  endtask

  task automatic t_unlock();
    logic [7:0] d;
    bus_write(2'd1, 8'h02);
    chk("R9 no key", mode, 0);
    bus_write(2'd0, 8'hA5);
    bus_read(2'd1, d);
    bus_write(2'd1, 8'h06);
    chk("R9 read cancels", {mode, clkout_en}, 3'b001);
    bus_write(2'd0, 8'hA5);
    bus_write(2'd2, 8'h00);
    bus_write(2'd1, 8'h06);
    bus_read(2'd1, d);
    chk("R9 other write cancels", {mode, d}, {2'd0, 8'h18});
    unlocked_write(8'h03);
    chk("R5 code 11 no request", mode, 0);
  endtask

  task automatic t_idle();
    logic [7:0] d;
    unlocked_write(8'h01);
    chk("R3 mode", mode, 2);
    chk("R3 enables", {osc_en, pll_en, cpu_clk_en, per_clk_en, clkout_en}, 5'b11000);
    bus_read(2'd1, d);
    chk("R11 readback", d, 8'h00);
    pulse_wake(1);
    chk("R10 nmi release", {cpu_clk_en, per_clk_en, mode}, 4'b1100);
  endtask

  task automatic t_stop_plain();
    int n = 0;
    unlocked_write(8'h02);
    chk("R5 mode", mode, 3);
    repeat (5) step();
    chk("R5 all off", {osc_en, pll_en, cpu_clk_en, per_clk_en, clkout_en}, 5'b00000);
    pulse_wake(0);
    chk("R6 osc only", {osc_en, pll_en, cpu_clk_en, mode}, 5'b10011);
    while (!cpu_clk_en && n < 5000) begin step(); n++; end
    chk("R6 sel0 length", n, 16);
  endtask

  task automatic t_stop_pll_lock();
    int n = 0;
    logic [7:0] d;
    unlocked_write(8'h2A);
    bus_read(2'd1, d);
    chk("R11 fields", d, 8'h28);
    chk("R5 mode", mode, 3);
    pulse_wake(1);
    while (!pll_en && n < 5000) begin step(); n++; end
    chk("R6 sel1 length", n, 64);
    chk("R7 pll wait clocks off", {osc_en, cpu_clk_en, per_clk_en, mode}, 5'b10011);
    repeat (3) step();
    chk("R7 still waiting", cpu_clk_en, 0);
    pll_lock = 1; step(); pll_lock = 0;
    chk("R7 lock release", {cpu_clk_en, mode}, 3'b100);
  endtask

  task automatic t_stop_pll_timeout();
    int n = 0;
    unlocked_write(8'h22);
    pulse_wake(0);
    while (!pll_en && n < 5000) begin step(); n++; end
    chk("R6 sel0 length with pll", n, 16);
    n = 0;
    while (!cpu_clk_en && n < 5000) begin step(); n++; end
    chk("R7 timeout length", n, 32);
  endtask

  task automatic t_clkout();
    unlocked_write(8'h04);
    chk("R8 inhibit in run", {cpu_clk_en, clkout_en}, 2'b10);
    halt_req = 1; step(); halt_req = 0;
    chk("R8 inhibit in halt", {per_clk_en, clkout_en}, 2'b10);
    pulse_wake(1);
    unlocked_write(8'h00);
    chk("R8 released", clkout_en, 1);
  endtask

  initial begin
    t_reset();
    t_halt();
    t_unlock();
    t_idle();
    t_stop_plain();
    t_stop_pll_lock();
    t_stop_pll_timeout();
    t_clkout();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule